// File: doc/BRIEF.md
# Local Countdown Timer with Power-of-Two Prescaler

This block is a 32-bit down-counter for a processor-local interrupt controller. It counts down from a software-written start value. The count steps on ticks from a prescaler whose division ratio is a power of two and is set by a small configuration field. The counter runs either once, stopping at zero, or repeatedly, reloading the start value after it has reached zero. The current value is always visible on an output.

When the count steps from one to zero, the block raises a one-cycle expiry event. The event carries the vector held in the timer's interrupt entry, so the interrupt unit can treat it as an edge-triggered fixed interrupt. A mask bit in the same entry silences the event but does not stop the counting.

Software reaches the block through a single write port. A 2-bit select picks the target: 0 for divide configuration, 1 for initial count, 2 for timer entry and 3 for current count. Address decoding and interrupt acceptance happen outside the block.

Top module: `local_countdown_timer`

## Requirements
- R1: A write with select 0 stores only bits 0, 1 and 3 of the data into the divide configuration. Bit 2 and bits 31:4 are dropped. The stored 4-bit value reads back on `div_rd`, with bit 2 always zero.
- R2: The divide code is the 3-bit value {cfg[3], cfg[1:0]}. The shift is (code + 1) mod 8, so code 7 divides by 1 and code 0 divides by 2. A running count drops by one every 2^shift clocks after an initial-count write.
- R3: A write with select 1 loads the data as both the initial and the current count at that clock edge. It restarts the prescaler phase. It takes priority over a tick at the same edge, which also cancels an expiry due at that edge.
- R4: With entry bit 17 clear (one-shot), the count falls to zero and stays there. It expires exactly once, N·2^shift clocks after loading N.
- R5: With entry bit 17 set (periodic), a tick at count zero reloads the initial value. Consecutive expiries are (N+1)·2^shift clocks apart.
- R6: The expiry output is high for exactly one cycle, the cycle after the edge where the count steps from 1 to 0. During that cycle `expire_vec` equals entry bits 7:0. `entry_rd` returns the stored vector (bits 7:0), mask (bit 16) and mode (bit 17), with all other bits zero.
- R7: With entry bit 16 set, no expiry is raised, but the count still runs as in R4 and R5.
- R8: A write with select 3 has no effect on the count or any other state.
- R9: An initial count of zero holds the count at zero and raises no expiry in either mode.
- R10: After reset the count is 0, `div_rd` is 0, `entry_rd` is 0x0001_0000 (masked, one-shot, vector 0) and `expire` is low.
- R11: A write with select 2 changes the mode from the next tick onward. A one-shot timer already at zero that is switched to periodic reloads its initial value on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 divide, 1 initial count, 2 timer entry, 3 current count |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count value |
| div_rd | output | 4 | Stored divide configuration |
| entry_rd | output | 32 | Stored timer entry (vector, mask, mode) |
| expire | output | 1 | One-cycle expiry event |
| expire_vec | output | 8 | Vector carried with the expiry event |

## Verification
The two events that can share one clock edge are an initial-count write and the tick that would move the count from 1 to 0. The bench loads a short count at divide-by-1 and times a second initial-count write to land on exactly the edge where expiry is due. In the following cycle it requires that `expire` is low and that the count equals the new value. It then requires a full fresh countdown before the next expiry. The same approach is used for the prescaler phase: the count is reloaded partway through a prescale interval, and the bench checks that the first expiry comes a whole N·2^shift clocks after the reload.

// File: rtl/lct_pkg.sv
package lct_pkg;

  typedef enum logic [1:0] {
    SEL_DIV   = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_CUR   = 2'd3
  } wsel_e;

  localparam logic [3:0] DIV_KEEP = 4'b1011;

  // Pack the scattered divide bits into a contiguous code.
  function automatic logic [2:0] div_code(input logic [3:0] cfg);
    return {cfg[3], cfg[1:0]};
  endfunction

  // Shift amount: code plus one, wrapping within three bits.
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PW = (1 << SHIFT_W) - 1;

  logic [PW-1:0] phase_q;
  logic [PW:0]   one_hot;
  logic [PW-1:0] low_mask;

  always_comb begin
    one_hot  = {{PW{1'b0}}, 1'b1} << shift;
    low_mask = PW'(one_hot - 1'b1);
  end

  assign tick = ((phase_q & low_mask) == low_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != '0) |=> (!tick || !$stable(shift))); // R2
  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && shift != '0) |=> !tick); // R3

endmodule

// File: rtl/lct_countdown.sv
module lct_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] count_q;
  logic             at_zero;

  assign at_zero = (count_q == '0);
  assign count   = count_q;
  assign hit     = tick && !load && (count_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= '0;
      count_q <= '0;
    end else if (load) begin
      init_q  <= load_val;
      count_q <= load_val;
    end else if (tick) begin
      if (!at_zero)      count_q <= count_q - 1'b1;
      else if (periodic) count_q <= init_q;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !at_zero) |=> count == $past(count) - CNT_W'(1)); // R2
  AST_ONESHOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !periodic && !load) |=> count == '0); // R4
  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_zero && periodic) |=> count == $past(init_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count)); // R8

endmodule

// File: rtl/lct_entry.sv
module lct_entry #(
  parameter int VEC_W    = 8,
  parameter int ENTRY_W  = 32,
  parameter int MASK_BIT = 16,
  parameter int PER_BIT  = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [VEC_W-1:0]   wr_vec,
  input  logic               wr_mask,
  input  logic               wr_per,
  input  logic               hit,
  output logic               periodic,
  output logic [ENTRY_W-1:0] entry_rd,
  output logic               expire,
  output logic [VEC_W-1:0]   expire_vec
);
  logic [VEC_W-1:0] vec_q;
  logic             mask_q;
  logic             per_q;
  logic             fire;

  assign periodic = per_q;
  assign fire     = hit && !mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
    end else if (wr) begin
      vec_q  <= wr_vec;
      mask_q <= wr_mask;
      per_q  <= wr_per;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expire     <= 1'b0;
      expire_vec <= '0;
    end else begin
      expire <= fire;
      if (fire) expire_vec <= vec_q;
    end
  end

  always_comb begin
    entry_rd              = '0;
    entry_rd[VEC_W-1:0]   = vec_q;
    entry_rd[MASK_BIT]    = mask_q;
    entry_rd[PER_BIT]     = per_q;
  end

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mask_q) |=> !expire); // R7
  AST_HIT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mask_q) |=> (expire && expire_vec == $past(vec_q))); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R6

endmodule

// File: rtl/local_countdown_timer.sv
module local_countdown_timer #(
  parameter int CNT_W    = 32,
  parameter int VEC_W    = 8,
  parameter int MASK_BIT = 16,
  parameter int PER_BIT  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cur_count,
  output logic [3:0]       div_rd,
  output logic [CNT_W-1:0] entry_rd,
  output logic             expire,
  output logic [VEC_W-1:0] expire_vec
);
  import lct_pkg::*;

  localparam int SHIFT_W = 3;

  logic [3:0]         div_q;
  logic [SHIFT_W-1:0] shift;
  logic               wr_div, wr_init, wr_entry, wr_cur;
  logic               tick, hit, periodic;

  assign wr_div   = wr_en && (wr_sel == SEL_DIV);
  assign wr_init  = wr_en && (wr_sel == SEL_INIT);
  assign wr_entry = wr_en && (wr_sel == SEL_ENTRY);
  assign wr_cur   = wr_en && (wr_sel == SEL_CUR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (wr_div) div_q <= wr_data[3:0] & DIV_KEEP;
  end

  assign div_rd = div_q;
  assign shift  = div_shift(div_code(div_q));

  lct_prescaler #(.SHIFT_W(SHIFT_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_init),
    .shift   (shift),
    .tick    (tick)
  );

  lct_countdown #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_init),
    .load_val (wr_data),
    .tick     (tick),
    .periodic (periodic),
    .count    (cur_count),
    .hit      (hit)
  );

  lct_entry #(
    .VEC_W    (VEC_W),
    .ENTRY_W  (CNT_W),
    .MASK_BIT (MASK_BIT),
    .PER_BIT  (PER_BIT)
  ) u_entry (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (wr_entry),
    .wr_vec     (wr_data[VEC_W-1:0]),
    .wr_mask    (wr_data[MASK_BIT]),
    .wr_per     (wr_data[PER_BIT]),
    .hit        (hit),
    .periodic   (periodic),
    .entry_rd   (entry_rd),
    .expire     (expire),
    .expire_vec (expire_vec)
  );

  AST_CUR_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur && !tick) |=> ($stable(cur_count) && $stable(div_rd) && $stable(entry_rd))); // R8
  AST_DIV_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> (div_rd[2] == 1'b0 && div_rd[0] == $past(wr_data[0]) && div_rd[3] == $past(wr_data[3]))); // R1

endmodule

// File: tb/local_countdown_timer_test.sv
module local_countdown_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] cur_count;
  logic [3:0]  div_rd;
  logic [31:0] entry_rd;
  logic        expire;
  logic [7:0]  expire_vec;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  local_countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_count(cur_count), .div_rd(div_rd), .entry_rd(entry_rd),
    .expire(expire), .expire_vec(expire_vec)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  task automatic wait_pulse(input int limit, output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!expire && c < limit);
  endtask

  function automatic logic [31:0] entry_word(input bit per, input bit msk, input logic [7:0] v);
    return (32'(per) << 17) | (32'(msk) << 16) | 32'(v);
  endfunction

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(cur_count == 32'd0, "R10 count", cur_count, 32'd0);
    check(div_rd == 4'd0, "R10 div", {28'd0, div_rd}, 32'd0);
    check(entry_rd == 32'h0001_0000, "R10 entry", entry_rd, 32'h0001_0000);
    check(expire == 1'b0, "R10 expire", {31'd0, expire}, 32'd0);

    // R1 divide field filtering
    wr(2'd0, 32'hFFFF_FFF6);
    check(div_rd == 4'h2, "R1 keep", {28'd0, div_rd}, 32'h2);
    wr(2'd0, 32'hFFFF_FFFF);
    check(div_rd == 4'hB, "R1 keep", {28'd0, div_rd}, 32'hB);

    // R6 entry readback fields
    wr(2'd2, 32'hFFFF_FFAA);
    check(entry_rd == 32'h0003_00AA, "R6 entry fields", entry_rd, 32'h0003_00AA);
    wr(2'd1, 32'd0);

    // R2 R4 R6 one-shot sweep over every divide code
    for (int code = 0; code < 8; code++) begin
      int s;
      s = (code + 1) % 8;
      for (int n = 1; n <= 3; n++) begin
        logic [7:0] v;
        v = 8'(8'h40 + code * 4 + n);
        wr(2'd2, entry_word(1'b0, 1'b0, v));
        wr(2'd0, 32'hFFFF_FFF4 | ((code >> 2) << 3) | (code & 3));
        wr(2'd1, 32'(n));
        for (int k = 1; k <= ((n + 1) << s) + 2; k++) begin
          int stepped;
          logic [31:0] expc;
          bit expp;
          @(negedge clk);
          stepped = k >> s;
          expc = (stepped >= n) ? 32'd0 : 32'(n - stepped);
          expp = (k == (n << s));
          check(cur_count == expc, "R2 count", cur_count, expc);
          check(expire == expp, "R4 expire", {31'd0, expire}, {31'd0, expp});
          if (expp) check(expire_vec == v, "R6 vector", {24'd0, expire_vec}, {24'd0, v});
        end
      end
    end

    // R5 periodic spacing
    for (int i = 0; i < 3; i++) begin
      int code, s, c2;
      code = (i == 0) ? 7 : ((i == 1) ? 0 : 2);
      s = (code + 1) % 8;
      for (int n = 1; n <= 3; n += 2) begin
        wr(2'd2, entry_word(1'b1, 1'b0, 8'h55));
        wr(2'd0, ((code >> 2) << 3) | (code & 3));
        wr(2'd1, 32'(n));
        wait_pulse(((n + 2) << s) + 4, c);
        check(c == (n << s), "R5 first", 32'(c), 32'(n << s));
        check(expire_vec == 8'h55, "R6 vector", {24'd0, expire_vec}, 32'h55);
        wait_pulse(((n + 2) << s) + 4, c2);
        check(c2 == ((n + 1) << s), "R5 gap", 32'(c2), 32'((n + 1) << s));
        wr(2'd1, 32'd0);
      end
    end

    // R7 mask suppresses expiry, count still runs
    wr(2'd2, entry_word(1'b0, 1'b1, 8'h77));
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd4);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(expire == 1'b0, "R7 masked", {31'd0, expire}, 32'd0);
    end
    check(cur_count == 32'd0, "R7 count", cur_count, 32'd0);

    // R8 write to current count ignored
    wr(2'd2, entry_word(1'b0, 1'b0, 8'h31));
    wr(2'd1, 32'd10);
    wr(2'd3, 32'h0000_1234);
    check(cur_count == 32'd9, "R8 ignored", cur_count, 32'd9);
    check(div_rd == 4'hB, "R8 div kept", {28'd0, div_rd}, 32'hB);
    wait_pulse(20, c);
    check(c == 9, "R8 expiry", 32'(c), 32'd9);

    // R9 zero initial count in periodic mode
    wr(2'd2, entry_word(1'b1, 1'b0, 8'h12));
    wr(2'd1, 32'd0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(expire == 1'b0 && cur_count == 32'd0, "R9 idle", cur_count, 32'd0);
    end

    // R3 reload mid-count restarts
    wr(2'd2, entry_word(1'b0, 1'b0, 8'h21));
    wr(2'd1, 32'd5);
    @(negedge clk);
    wr(2'd1, 32'd3);
    check(cur_count == 32'd3, "R3 reload", cur_count, 32'd3);
    wait_pulse(10, c);
    check(c == 3, "R3 restart expiry", 32'(c), 32'd3);

    // R3 reload on the expiry edge wins
    wr(2'd1, 32'd3);
    @(negedge clk);
    @(negedge clk);
    check(cur_count == 32'd1, "R3 pre-collision", cur_count, 32'd1);
    wr(2'd1, 32'd4);
    check(expire == 1'b0, "R3 collision no expire", {31'd0, expire}, 32'd0);
    check(cur_count == 32'd4, "R3 collision count", cur_count, 32'd4);
    wait_pulse(10, c);
    check(c == 4, "R3 collision expiry", 32'(c), 32'd4);

    // R3 prescaler phase restarts on load
    wr(2'd0, 32'h1);
    wr(2'd1, 32'd2);
    repeat (3) @(negedge clk);
    wr(2'd1, 32'd2);
    wait_pulse(20, c);
    check(c == 8, "R3 phase restart", 32'(c), 32'd8);

    // R11 mode switch after one-shot end
    wr(2'd0, 32'hB);
    wr(2'd2, entry_word(1'b0, 1'b0, 8'h66));
    wr(2'd1, 32'd2);
    wait_pulse(10, c);
    check(c == 2, "R11 one-shot", 32'(c), 32'd2);
    wr(2'd2, entry_word(1'b1, 1'b0, 8'h66));
    check(cur_count == 32'd0, "R11 at zero", cur_count, 32'd0);
    @(negedge clk);
    check(cur_count == 32'd2, "R11 reload", cur_count, 32'd2);
    wait_pulse(10, c);
    check(c == 2, "R11 periodic expiry", 32'(c), 32'd2);
    wr(2'd1, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule